// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block carries out the atomic store-class instructions of a 64-bit register machine. A request carries the raw 8-bit opcode, the 32-bit immediate, the signed 16-bit offset, and the values of three registers: the base register that forms the address, the source register, and the fixed register R0. It is presented on a valid/ready handshake. The unit decodes the request and reads the target location with the memory lock raised. It then works out the new value, writes it back under the same lock, and returns a response. The response holds the value the location had before the operation, plus write enables telling the register file whether that value goes to the source register, to R0, or nowhere.

The memory port is a simple synchronous port with no back-pressure. It carries a request strobe, a write flag, a byte address, 64-bit write data, byte strobes and a lock line, and read data is returned exactly one cycle after a read request. In 32-bit operation only one half of the 64-bit memory word is touched. The address bit of weight 4 selects which half.

Top module: `atomic_rmw_unit`

## Requirements
- R1: An opcode is accepted as atomic only when its low three bits hold 3, its top three bits hold 6, and bits [4:3] hold 0 (32-bit, opcode 0xC3) or 3 (64-bit, opcode 0xDB); any other opcode gives an illegal response.
- R2: The byte address driven on the memory port is the base register plus the offset sign-extended from 16 bits, with wrap-around.
- R3: Immediates 0x00, 0x40, 0x50 and 0xA0 store old+src, old|src, old&src and old^src; in 32-bit operation the result wraps at 32 bits.
- R4: The same four codes with bit 0 set (0x01, 0x41, 0x51, 0xA1) behave identically but also return the old memory value through the source-register write enable; without bit 0 no register is written.
- R5: Immediate 0xE1 stores the source value and returns the old value to the source register.
- R6: Immediate 0xF1 compares the old value with R0 (low 32 bits in 32-bit operation). It stores the source value only on equality and issues no write otherwise, and in both cases it returns the old value to R0 and does not write the source register.
- R7: In 32-bit operation, address bit 2 selects the upper (strobes 0xF0) or lower (strobes 0x0F) half. Write data is replicated into both halves, and returned values are zero-extended. 64-bit operation uses strobes 0xFF.
- R8: Any other immediate, or an illegal opcode, produces a response with the illegal flag set and both register write enables low, one cycle after acceptance, with no memory request.
- R9: A legal request issues its read one cycle after acceptance and its write three cycles after acceptance; lock is high from the read through the write. The response follows one cycle later, or three cycles after acceptance when a compare-exchange does not match.
- R10: Ready is low from acceptance until the response handshake completes, and the response fields stay unchanged while valid is held without ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_opcode | input | 8 | Raw instruction opcode |
| req_imm | input | 32 | Immediate selecting the operation |
| req_offset | input | 16 | Signed address offset |
| req_base | input | 64 | Base register value |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | R0 value (compare operand) |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Location locked for read-modify-write |
| mem_addr | output | 64 | Byte address |
| mem_be | output | 8 | Byte strobes |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, one cycle after a read request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_illegal | output | 1 | Request was not a legal atomic |
| rsp_src_we | output | 1 | Write rsp_src_val to the source register |
| rsp_src_val | output | 64 | Old memory value for the source register |
| rsp_r0_we | output | 1 | Write rsp_r0_val to R0 |
| rsp_r0_val | output | 64 | Old memory value for R0 |

## Verification
Measured from the clock edge that accepts a legal request, the read strobe is due one cycle later, the write three cycles later and the response four cycles later. A mismatching compare-exchange responds after three cycles, and an illegal request responds after one. The bench walks these cycles one falling edge at a time. At each falling edge it compares strobes, lock, address, lane data and response fields with a behavioural model of what that cycle must show. Memory contents are then checked through the bench's own memory after each response handshake.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int XLEN     = 64;
  localparam int HLEN     = XLEN / 2;
  localparam int NBYTE    = XLEN / 8;
  localparam int LANE_BIT = $clog2(NBYTE) - 1;

  localparam logic [2:0] CLS_STORE_REG = 3'd3;
  localparam logic [2:0] MODE_ATOMIC   = 3'd6;
  localparam logic [1:0] SZ_WORD       = 2'd0;
  localparam logic [1:0] SZ_DWORD      = 2'd3;

  typedef enum logic [2:0] {
    OP_ADD, OP_OR, OP_AND, OP_XOR, OP_XCHG, OP_CMPX
  } atom_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_MODIFY, ST_WRITE, ST_RESP
  } atom_state_e;

  // zero the upper half when operating on 32 bits
  function automatic logic [XLEN-1:0] narrow(input logic [XLEN-1:0] v, input logic wide);
    return wide ? v : {{HLEN{1'b0}}, v[HLEN-1:0]};
  endfunction

  // new memory value for a given operation
  function automatic logic [XLEN-1:0] combine(input atom_op_e op, input logic [XLEN-1:0] old,
                                              input logic [XLEN-1:0] src, input logic wide);
    logic [XLEN-1:0] r;
    case (op)
      OP_ADD:  r = old + src;
      OP_OR:   r = old | src;
      OP_AND:  r = old & src;
      OP_XOR:  r = old ^ src;
      default: r = src;
    endcase
    return narrow(r, wide);
  endfunction

  // select the addressed half of a read word
  function automatic logic [XLEN-1:0] lane_pick(input logic [XLEN-1:0] rdata, input logic hi,
                                                input logic wide);
    logic [XLEN-1:0] shifted;
    shifted = hi ? {{HLEN{1'b0}}, rdata[XLEN-1:HLEN]} : rdata;
    return narrow(shifted, wide);
  endfunction

  // place a value onto the write bus (replicated for half-width)
  function automatic logic [XLEN-1:0] lane_place(input logic [XLEN-1:0] v, input logic wide);
    return wide ? v : {2{v[HLEN-1:0]}};
  endfunction

  function automatic logic [NBYTE-1:0] lane_strobe(input logic hi, input logic wide);
    logic [NBYTE-1:0] half;
    half = {{(NBYTE/2){1'b0}}, {(NBYTE/2){1'b1}}};
    if (wide) return '1;
    return hi ? (half << (NBYTE/2)) : half;
  endfunction

  function automatic logic operands_equal(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                          input logic wide);
    return narrow(a, wide) == narrow(b, wide);
  endfunction
endpackage

// File: rtl/atom_decode.sv
module atom_decode
  import atom_pkg::*;
(
  input  logic [7:0]  opcode,
  input  logic [31:0] imm,
  output logic        legal,
  output atom_op_e    op,
  output logic        fetch,
  output logic        wide
);
  logic fmt_ok;
  logic imm_ok;

  always_comb begin
    fmt_ok = (opcode[2:0] == CLS_STORE_REG) && (opcode[7:5] == MODE_ATOMIC) &&
             ((opcode[4:3] == SZ_WORD) || (opcode[4:3] == SZ_DWORD));
    wide   = (opcode[4:3] == SZ_DWORD);
    op     = OP_ADD;
    fetch  = 1'b0;
    imm_ok = 1'b1;
    case (imm)
      32'h00, 32'h01: begin op = OP_ADD; fetch = imm[0]; end
      32'h40, 32'h41: begin op = OP_OR;  fetch = imm[0]; end
      32'h50, 32'h51: begin op = OP_AND; fetch = imm[0]; end
      32'ha0, 32'ha1: begin op = OP_XOR; fetch = imm[0]; end
      32'he1:         begin op = OP_XCHG; fetch = 1'b1; end
      32'hf1:         begin op = OP_CMPX; fetch = 1'b0; end
      default:        imm_ok = 1'b0;
    endcase
    legal = fmt_ok && imm_ok;
  end
endmodule

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
(
  input  atom_op_e        op,
  input  logic            wide,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] cmp_val,
  output logic [XLEN-1:0] new_val,
  output logic            do_write
);
  logic match;
  always_comb begin
    new_val  = combine(op, old_val, src_val, wide);
    match    = operands_equal(old_val, cmp_val, wide);
    do_write = (op != OP_CMPX) || match;
  end
endmodule

// File: rtl/atom_ctrl.sv
module atom_ctrl
  import atom_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_legal,
  input  logic        write_needed,
  input  logic        rsp_taken,
  output atom_state_e state
);
  atom_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = start_legal ? ST_READ : ST_RESP;
      ST_READ:   nxt = ST_MODIFY;
      ST_MODIFY: nxt = write_needed ? ST_WRITE : ST_RESP;
      ST_WRITE:  nxt = ST_RESP;
      ST_RESP:   if (rsp_taken) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atom_pkg::*;
#(
  parameter int AW   = 64,
  parameter int OFFW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [31:0]       req_imm,
  input  logic [OFFW-1:0]   req_offset,
  input  logic [XLEN-1:0]   req_base,
  input  logic [XLEN-1:0]   req_src,
  input  logic [XLEN-1:0]   req_r0,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [AW-1:0]     mem_addr,
  output logic [NBYTE-1:0]  mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_illegal,
  output logic              rsp_src_we,
  output logic [XLEN-1:0]   rsp_src_val,
  output logic              rsp_r0_we,
  output logic [XLEN-1:0]   rsp_r0_val
);
  // decoded request at the input
  logic      acc_legal, acc_fetch, acc_wide;
  atom_op_e  acc_op;
  logic [AW-1:0] acc_addr;

  // named internal events
  logic ev_accept, ev_rsp_done;
  logic in_read, in_modify, in_write, in_resp;

  // captured request
  logic            legal_q, fetch_q, wide_q;
  atom_op_e        op_q;
  logic [AW-1:0]   addr_q;
  logic [XLEN-1:0] src_q, r0_q, old_q, new_q;

  // modify stage
  logic [XLEN-1:0] old_lane, alu_new;
  logic            alu_write;
  atom_state_e     state;

  atom_decode u_dec (
    .opcode (req_opcode),
    .imm    (req_imm),
    .legal  (acc_legal),
    .op     (acc_op),
    .fetch  (acc_fetch),
    .wide   (acc_wide)
  );

  assign acc_addr = req_base[AW-1:0] + AW'({{(XLEN-OFFW){req_offset[OFFW-1]}}, req_offset});

  assign in_read   = (state == ST_READ);
  assign in_modify = (state == ST_MODIFY);
  assign in_write  = (state == ST_WRITE);
  assign in_resp   = (state == ST_RESP);

  assign req_ready   = (state == ST_IDLE);
  assign ev_accept   = req_valid && req_ready;
  assign ev_rsp_done = in_resp && rsp_ready;

  assign old_lane = lane_pick(mem_rdata, addr_q[LANE_BIT], wide_q);

  atom_alu u_alu (
    .op       (op_q),
    .wide     (wide_q),
    .old_val  (old_lane),
    .src_val  (src_q),
    .cmp_val  (r0_q),
    .new_val  (alu_new),
    .do_write (alu_write)
  );

  atom_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (ev_accept),
    .start_legal  (acc_legal),
    .write_needed (alu_write),
    .rsp_taken    (rsp_ready),
    .state        (state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      legal_q <= 1'b0;
      fetch_q <= 1'b0;
      wide_q  <= 1'b0;
      op_q    <= OP_ADD;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
      new_q   <= '0;
    end else begin
      if (ev_accept) begin
        legal_q <= acc_legal;
        fetch_q <= acc_fetch;
        wide_q  <= acc_wide;
        op_q    <= acc_op;
        addr_q  <= acc_addr;
        src_q   <= req_src;
        r0_q    <= req_r0;
        old_q   <= '0;
      end
      if (in_modify) begin
        old_q <= old_lane;
        new_q <= alu_new;
      end
    end
  end

  // memory port
  assign mem_req   = in_read || in_write;
  assign mem_we    = in_write;
  assign mem_lock  = in_read || in_modify || in_write;
  assign mem_addr  = addr_q;
  assign mem_be    = lane_strobe(addr_q[LANE_BIT], wide_q);
  assign mem_wdata = lane_place(new_q, wide_q);

  // response
  assign rsp_valid   = in_resp;
  assign rsp_illegal = !legal_q;
  assign rsp_src_we  = legal_q && fetch_q;
  assign rsp_r0_we   = legal_q && (op_q == OP_CMPX);
  assign rsp_src_val = old_q;
  assign rsp_r0_val  = old_q;
endmodule

// File: rtl/atomic_rmw_checks.sv
module atomic_rmw_checks
  import atom_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ev_accept,
  input logic             acc_legal,
  input logic             req_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_lock,
  input logic [NBYTE-1:0] mem_be,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_illegal,
  input logic             rsp_src_we,
  input logic             rsp_r0_we,
  input logic [XLEN-1:0]  rsp_src_val,
  input logic [XLEN-1:0]  rsp_r0_val
);
  // R9
  lock_covers_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  // R9
  write_follows_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_lock));

  // R9
  read_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && acc_legal) |=> (mem_req && !mem_we));

  // R8
  illegal_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !acc_legal) |=> (!mem_req && rsp_valid && rsp_illegal));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (!rsp_src_we && !rsp_r0_we));

  // R7
  lane_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 8'hFF || mem_be == 8'hF0 || mem_be == 8'h0F));

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_src_val) && $stable(rsp_r0_val)
                                   && $stable(rsp_illegal)));
endmodule

bind atomic_rmw_unit atomic_rmw_checks u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_accept   (ev_accept),
  .acc_legal   (acc_legal),
  .req_ready   (req_ready),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_lock    (mem_lock),
  .mem_be      (mem_be),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_illegal (rsp_illegal),
  .rsp_src_we  (rsp_src_we),
  .rsp_r0_we   (rsp_r0_we),
  .rsp_src_val (rsp_src_val),
  .rsp_r0_val  (rsp_r0_val)
);

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [7:0]  req_opcode = '0;
  logic [31:0] req_imm = '0;
  logic [15:0] req_offset = '0;
  logic [63:0] req_base = '0, req_src = '0, req_r0 = '0;
  logic        mem_req, mem_we, mem_lock;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  mem_be;
  logic        rsp_valid, rsp_ready = 1'b1, rsp_illegal, rsp_src_we, rsp_r0_we;
  logic [63:0] rsp_src_val, rsp_r0_val;

  atomic_rmw_unit dut (.*);

  // bench memory: 16 words, read data one cycle after request
  logic [63:0] bmem [16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++)
        bmem[i] <= {8'hC0 + 8'(i), 24'h00FFFF, 8'h7F, 16'hFFFF, 8'hF0 + 8'(i)};
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we)
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) bmem[mem_addr[6:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
      mem_rdata <= bmem[mem_addr[6:3]];
    end
  end

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // behavioural expectation of one atomic operation
  task automatic model(input logic [31:0] imm, input bit wide, input logic [63:0] old,
                       input logic [63:0] src, input logic [63:0] r0,
                       output logic [63:0] nv, output bit wr, output bit swe, output bit r0we);
    logic [63:0] m;
    m = wide ? ~64'd0 : 64'h0000_0000_FFFF_FFFF;
    wr = 1; swe = imm[0]; r0we = 0;
    if (imm == 32'h00 || imm == 32'h01) nv = (old + src) & m;
    else if (imm == 32'h40 || imm == 32'h41) nv = (old | src) & m;
    else if (imm == 32'h50 || imm == 32'h51) nv = old & src & m;
    else if (imm == 32'ha0 || imm == 32'ha1) nv = (old ^ src) & m;
    else if (imm == 32'he1) nv = src & m;
    else begin
      nv = src & m; swe = 0; r0we = 1;
      wr = ((old & m) == (r0 & m));
    end
  endtask

  task automatic run_op(input string tag, input logic [7:0] opc, input logic [31:0] imm,
                        input logic [15:0] off, input logic [63:0] base, input logic [63:0] src,
                        input logic [63:0] r0, input int stall);
    bit legal, wide, hi, wr, swe, r0we;
    logic [63:0] addr, word, old, nv, exp_word, wlane;
    int idx;
    legal = (opc == 8'hC3 || opc == 8'hDB) &&
            (imm inside {32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51, 32'ha0, 32'ha1, 32'he1, 32'hf1});
    wide = (opc == 8'hDB);
    addr = base + {{48{off[15]}}, off};
    idx = int'(addr[6:3]);
    hi = addr[2];
    word = bmem[idx];
    old = wide ? word : (hi ? {32'd0, word[63:32]} : {32'd0, word[31:0]});
    model(imm, wide, old, src, r0, nv, wr, swe, r0we);
    if (!legal) begin wr = 0; swe = 0; r0we = 0; end
    exp_word = !wr ? word : wide ? nv : hi ? {nv[31:0], word[31:0]} : {word[63:32], nv[31:0]};

    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R10 ready when idle"}, 64'(req_ready), 64'd1);
    req_opcode = opc; req_imm = imm; req_offset = off;
    req_base = base; req_src = src; req_r0 = r0; req_valid = 1'b1;
    rsp_ready = (stall == 0);
    @(negedge clk);
    req_valid = 1'b0;
    if (legal) begin
      // read cycle
      chk(mem_req && !mem_we && mem_lock, {tag, " R9 read cycle"}, {mem_req, mem_we, mem_lock}, 3'b101);
      chk(mem_addr == addr, {tag, " R2 address"}, mem_addr, addr);
      chk(mem_be == (wide ? 8'hFF : hi ? 8'hF0 : 8'h0F), {tag, " R7 strobes"}, 64'(mem_be),
          64'(wide ? 8'hFF : hi ? 8'hF0 : 8'h0F));
      chk(!req_ready, {tag, " R10 busy"}, 64'(req_ready), 64'd0);
      @(negedge clk);
      // modify cycle
      chk(!mem_req && mem_lock, {tag, " R9 modify cycle"}, {mem_req, mem_lock}, 2'b01);
      @(negedge clk);
      if (wr) begin
        wlane = wide ? mem_wdata : (hi ? {32'd0, mem_wdata[63:32]} : {32'd0, mem_wdata[31:0]});
        chk(mem_req && mem_we && mem_lock, {tag, " R9 write cycle"}, {mem_req, mem_we, mem_lock}, 3'b111);
        chk(wlane == nv, {tag, " R3 write value"}, wlane, nv);
        chk(wide || mem_wdata[63:32] == mem_wdata[31:0], {tag, " R7 replicated data"},
            mem_wdata, {2{nv[31:0]}});
        @(negedge clk);
      end
    end
    // response cycle
    chk(rsp_valid && !mem_req && !mem_lock, {tag, " R9 response cycle"},
        {rsp_valid, mem_req, mem_lock}, 3'b100);
    chk(rsp_illegal == !legal, {tag, " R8 illegal flag"}, 64'(rsp_illegal), 64'(!legal));
    chk(rsp_src_we == swe, {tag, " R4 source write enable"}, 64'(rsp_src_we), 64'(swe));
    chk(rsp_r0_we == r0we, {tag, " R6 R0 write enable"}, 64'(rsp_r0_we), 64'(r0we));
    if (swe) chk(rsp_src_val == old, {tag, " R4 fetched value"}, rsp_src_val, old);
    if (r0we) chk(rsp_r0_val == old, {tag, " R6 R0 value"}, rsp_r0_val, old);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready, {tag, " R10 response held"}, {rsp_valid, req_ready}, 2'b10);
      chk(rsp_src_val == old, {tag, " R10 held value"}, rsp_src_val, old);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, {tag, " R10 back to idle"}, {rsp_valid, req_ready}, 2'b01);
    chk(bmem[idx] == exp_word, {tag, " R3 memory contents"}, bmem[idx], exp_word);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req && !mem_lock, "R10 reset state",
        {req_ready, rsp_valid, mem_req, mem_lock}, 4'b1000);
    // R3 add, 32-bit, low lane, no fetch
    run_op("add32", 8'hC3, 32'h00, 16'h0008, 64'h100, 64'h8000_0010, 0, 0);
    // R4 add with fetch, 64-bit wrap
    run_op("addf64", 8'hDB, 32'h01, 16'h0000, 64'h118, 64'hF000_0000_0000_0001, 0, 0);
    // R7 or with fetch, upper lane, negative offset (R2)
    run_op("orf32hi", 8'hC3, 32'h41, 16'hFFFC, 64'h130, 64'h0000_0000_0102_0304, 0, 0);
    run_op("and64", 8'hDB, 32'h50, 16'h0010, 64'h120, 64'hFF00_FF00_0F0F_F0F0, 0, 0);
    run_op("xorf32", 8'hC3, 32'ha1, 16'h0000, 64'h148, 64'hDEAD_BEEF_FFFF_FFFF, 0, 0);
    run_op("andf32", 8'hC3, 32'h51, 16'h0004, 64'h150, 64'h0000_0000_FFFF_00FF, 0, 0);
    // R5 exchange
    run_op("xchg64", 8'hDB, 32'he1, 16'h0000, 64'h158, 64'h1234_5678_9ABC_DEF0, 0, 0);
    // R6 compare-exchange match (32-bit; upper bits of R0 ignored)
    run_op("cmpx32hit", 8'hC3, 32'hf1, 16'h0000, 64'h160, 64'h0000_0000_CAFE_F00D,
           64'hFFFF_FFFF_7FFF_FFFC, 0);
    // R6 compare-exchange mismatch (64-bit) - no write
    run_op("cmpx64miss", 8'hDB, 32'hf1, 16'h0000, 64'h168, 64'h5555, 64'h1, 0);
    // R8 illegal immediate
    run_op("badimm", 8'hDB, 32'h30, 16'h0000, 64'h170, 64'h1, 0, 0);
    // R1 illegal size (byte) and wrong class
    run_op("badsize", 8'hD3, 32'h00, 16'h0000, 64'h178, 64'h1, 0, 0);
    run_op("badclass", 8'hC2, 32'h00, 16'h0000, 64'h178, 64'h1, 0, 0);
    // R10 stalled response
    run_op("stall", 8'hDB, 32'h01, 16'h0000, 64'h108, 64'h10, 0, 3);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule